// File: doc/BRIEF.md
# Extended Instruction Target-Address Unit

This block sits in the decode path of a processor core with a 20-bit byte address space. It receives the first four bytes of an instruction, a hint that marks one-byte and two-byte opcodes, and the current base, index and program-counter values. The program counter has already been advanced past the instruction. From these it finds the instruction length and the target address, and it reports how the operand is to be used. For the memory-referencing formats, six flag bits sit between the opcode and the address field. They choose the address arithmetic (base-relative, PC-relative or direct, each optionally indexed) and the operand use (immediate, indirect or simple).

A request is offered with `req_valid`. It is taken on a rising edge where `req_ready` is high. `req_ready` is high only while no request is in flight, so a caller holds `req_valid` and the instruction inputs until that edge. For indirect use, the block fetches the pointer word through its own read port. `rd_valid` rises with `rd_addr` set to the target address. Both stay unchanged until the memory side answers with `rd_ready`, and `rd_data` is sampled on that same edge. The memory side may stall for any number of cycles. Once the operand address is resolved, `done` pulses for one cycle on the following edge. All result outputs then hold until the next request is taken.

Top module: `ext_ta_unit`

## Requirements
- R1: `fmt_cls` steers the length of the short formats. Bit 1 set gives length 2, and `fmt_cls`=01 gives length 1. Both report target address 0, operand address 0, immediate 0 and error 0, and never read memory.
- R2: With `fmt_cls`=00 the instruction is a memory format. `instr[31:24]` is the first byte, and bit 20 (e) picks the length: 3 when 0, 4 when 1. Flags sit at n=25, i=24, x=23, b=22, p=21. The 12-bit displacement is `instr[19:8]` when e=0, and the 20-bit address field is `instr[19:0]` when e=1.
- R3: With b=1 and p=0, the target address is `base_val` plus the field read as an unsigned value, modulo 2^20.
- R4: With b=0 and p=1, the target address is `pc_val` plus the field read as a two's-complement value, modulo 2^20. The field is 12 bits wide in the 3-byte format and 20 bits wide in the 4-byte format.
- R5: With b=0 and p=0, the field itself is the target address. With x=1, `index_val` is added in every mode. All sums wrap at 20 bits.
- R6: i=1 with n=0 sets `imm` to 1, makes the operand address equal to the target address, and issues no read.
- R7: n=1 with i=0 issues exactly one read at the target address. The read is held with a stable address until `rd_ready`, and the operand address becomes `rd_data[19:0]`.
- R8: When n and i are equal, `imm` is 0, the operand address equals the target address, and no read happens.
- R9: In a memory format, b=1 with p=1 sets `err` to 1 and forces the target address, operand address and `imm` to 0. No read happens, whatever n and i say.
- R10: `done` is a one-cycle pulse on the edge after the operand address is resolved. For a non-indirect request that is the second edge after acceptance. For an indirect request it is the edge after the read handshake. `req_ready` is high only while idle, and the results hold until the next accepted request.
- R11: After reset, `req_ready` is 1, and `done`, `rd_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; request taken on this edge if valid |
| instr | input | 32 | Instruction bytes, first byte in [31:24] |
| fmt_cls | input | 2 | 00 memory format, 01 one-byte, 1x two-byte |
| base_val | input | AW | Base register value |
| index_val | input | AW | Index register value |
| pc_val | input | AW | Program counter, already past the instruction |
| rd_valid | output | 1 | Indirect pointer read requested |
| rd_ready | input | 1 | Read answered; rd_data valid on this edge |
| rd_addr | output | AW | Read address (the target address) |
| rd_data | input | WW | Word returned by the read |
| done | output | 1 | One-cycle completion strobe |
| len | output | 3 | Instruction length in bytes |
| ta | output | AW | Target address |
| imm | output | 1 | Target address is the operand value |
| err | output | 1 | Illegal b/p combination |
| op_addr | output | AW | Resolved operand address |

## Verification
The assertions assume that the memory side raises `rd_ready` only while `rd_valid` is high, and that the caller holds its inputs stable on the acceptance edge. The bench meets both assumptions. Its read responder derives `rd_ready` only from an observed `rd_valid`, after a programmed stall. Requests are driven on falling edges and withdrawn as soon as they are taken. The mix of stall lengths covers zero and several cycles, so the hold-while-stalled and single-read properties are exercised under back-pressure.

// File: rtl/xar_pkg.sv
package xar_pkg;

  localparam int FIELD_W = 20;
  localparam int DISP_W  = 12;

  typedef struct packed {
    logic               is_mem;
    logic [2:0]         len;
    logic               n;
    logic               i;
    logic               x;
    logic               b;
    logic               p;
    logic               e;
    logic               err;
    logic               imm;
    logic               ind;
    logic [FIELD_W-1:0] field;
  } xar_dec_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_READ = 2'd1,
    SQ_FIN  = 2'd2
  } xar_state_e;

endpackage

// File: rtl/xar_decode.sv
module xar_decode
  import xar_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [1:0]  fmt_cls,
  output xar_dec_t    dec
);

  logic [5:0] unused_opcode;
  assign unused_opcode = instr[31:26];

  always_comb begin
    dec        = '0;
    dec.is_mem = (fmt_cls == 2'b00);
    dec.n      = instr[25];
    dec.i      = instr[24];
    dec.x      = instr[23];
    dec.b      = instr[22];
    dec.p      = instr[21];
    dec.e      = instr[20];
    dec.field  = instr[20] ? instr[19:0]
                           : {{(FIELD_W-DISP_W){1'b0}}, instr[19:8]};
    if (fmt_cls[1]) begin
      dec.len = 3'd2;
    end else if (fmt_cls[0]) begin
      dec.len = 3'd1;
    end else begin
      dec.len = instr[20] ? 3'd4 : 3'd3;
    end
    dec.err = dec.is_mem & dec.b & dec.p;
    dec.imm = dec.is_mem & ~dec.err & dec.i & ~dec.n;
    dec.ind = dec.is_mem & ~dec.err & dec.n & ~dec.i;
  end

endmodule

// File: rtl/xar_addr_calc.sv
module xar_addr_calc
  import xar_pkg::*;
#(
  parameter int AW = 20
) (
  input  xar_dec_t      dec,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] pc_val,
  output logic [AW-1:0] ta
);

  logic [FIELD_W-1:0] fld_sext;
  logic [AW-1:0]      fld_zero_w;
  logic [AW-1:0]      fld_sign_w;
  logic [AW-1:0]      anchor;
  logic [AW-1:0]      offset;
  logic [AW-1:0]      idx_add;

  // 12-bit displacement sign-extends to the 20-bit field width
  assign fld_sext = dec.e ? dec.field
                          : {{(FIELD_W-DISP_W){dec.field[DISP_W-1]}},
                             dec.field[DISP_W-1:0]};

  generate
    if (AW > FIELD_W) begin : g_wide
      assign fld_zero_w = {{(AW-FIELD_W){1'b0}}, dec.field};
      assign fld_sign_w = {{(AW-FIELD_W){fld_sext[FIELD_W-1]}}, fld_sext};
    end else begin : g_exact
      assign fld_zero_w = dec.field[AW-1:0];
      assign fld_sign_w = fld_sext[AW-1:0];
    end
  endgenerate

  always_comb begin
    anchor  = '0;
    offset  = fld_zero_w;
    if (dec.b) begin
      anchor = base_val;
    end else if (dec.p) begin
      anchor = pc_val;
      offset = fld_sign_w;
    end
    idx_add = dec.x ? index_val : '0;
    if (!dec.is_mem || dec.err) begin
      ta = '0;
    end else begin
      ta = anchor + offset + idx_add;
    end
  end

endmodule

// File: rtl/xar_seq.sv
module xar_seq
  import xar_pkg::*;
#(
  parameter int AW = 20,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  xar_dec_t      dec,
  input  logic [AW-1:0] ta_in,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [WW-1:0] rd_data,
  output logic          done,
  output logic [2:0]    len,
  output logic [AW-1:0] ta,
  output logic          imm,
  output logic          err,
  output logic [AW-1:0] op_addr
);

  xar_state_e st_q;
  logic       fire;

  logic [WW-AW-1:0] unused_rd_hi;
  assign unused_rd_hi = rd_data[WW-1:AW];

  assign req_ready = (st_q == SQ_IDLE);
  assign fire      = req_valid & req_ready;
  assign rd_valid  = (st_q == SQ_READ);
  assign rd_addr   = ta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      done    <= 1'b0;
      len     <= '0;
      ta      <= '0;
      imm     <= 1'b0;
      err     <= 1'b0;
      op_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (fire) begin
            len <= dec.len;
            ta  <= ta_in;
            imm <= dec.imm;
            err <= dec.err;
            if (dec.ind) begin
              op_addr <= '0;
              st_q    <= SQ_READ;
            end else begin
              op_addr <= ta_in;
              st_q    <= SQ_FIN;
            end
          end
        end
        SQ_READ: begin
          if (rd_ready) begin
            op_addr <= rd_data[AW-1:0];
            st_q    <= SQ_FIN;
          end
        end
        SQ_FIN: begin
          done <= 1'b1;
          st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R7: stalled read keeps its request and address
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R7: one read per request
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: no completion on the edge right after acceptance
  a_r10_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !done);

endmodule

// File: rtl/ext_ta_unit.sv
module ext_ta_unit
  import xar_pkg::*;
#(
  parameter int AW = 20,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   instr,
  input  logic [1:0]    fmt_cls,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] pc_val,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [WW-1:0] rd_data,
  output logic          done,
  output logic [2:0]    len,
  output logic [AW-1:0] ta,
  output logic          imm,
  output logic          err,
  output logic [AW-1:0] op_addr
);

  xar_dec_t      dec;
  logic [AW-1:0] ta_comb;

  xar_decode u_decode (
    .instr   (instr),
    .fmt_cls (fmt_cls),
    .dec     (dec)
  );

  xar_addr_calc #(.AW(AW)) u_addr (
    .dec       (dec),
    .base_val  (base_val),
    .index_val (index_val),
    .pc_val    (pc_val),
    .ta        (ta_comb)
  );

  xar_seq #(.AW(AW), .WW(WW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dec       (dec),
    .ta_in     (ta_comb),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .done      (done),
    .len       (len),
    .ta        (ta),
    .imm       (imm),
    .err       (err),
    .op_addr   (op_addr)
  );

  // R9: illegal b/p never starts a read
  a_r9_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && dec.err |=> !rd_valid);

  // R6: immediate use never starts a read
  a_r6_imm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && dec.imm |=> !rd_valid);

  // R1: short formats never start a read
  a_r1_short_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dec.is_mem |=> !rd_valid);

endmodule

// File: tb/ext_ta_unit_test.sv
`timescale 1ns/1ps
module ext_ta_unit_test;

  localparam int AW = 20;
  localparam int WW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   instr = '0;
  logic [1:0]    fmt_cls = '0;
  logic [AW-1:0] base_val = '0;
  logic [AW-1:0] index_val = '0;
  logic [AW-1:0] pc_val = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_data = '0;
  logic          done;
  logic [2:0]    len;
  logic [AW-1:0] ta;
  logic          imm;
  logic          err;
  logic [AW-1:0] op_addr;

  always #2.5 clk = ~clk;

  ext_ta_unit #(.AW(AW), .WW(WW)) uut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state: 0 idle, 1 finishing, 2 reading
  int    m_state = 0;
  bit    m_done  = 0;
  bit    m_have  = 0;
  int    m_len = 0, m_ta = 0, m_imm = 0, m_err = 0, m_op = 0;
  string m_tag = "R11";
  string cur_tag = "R11";

  int rd_wait = 0;
  int rd_cnt  = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic predict(input logic [31:0] ins, input logic [1:0] fc,
                         input int bv, input int xv, input int pv,
                         output int o_len, output int o_ta, output int o_imm,
                         output int o_err, output int o_ind);
    int field, sd, t;
    bit n, i, x, b, p, e;
    o_len = 0; o_ta = 0; o_imm = 0; o_err = 0; o_ind = 0;
    if (fc[1]) begin
      o_len = 2;
    end else if (fc[0]) begin
      o_len = 1;
    end else begin
      n = ins[25]; i = ins[24]; x = ins[23];
      b = ins[22]; p = ins[21]; e = ins[20];
      o_len = e ? 4 : 3;
      field = e ? int'(ins[19:0]) : int'(ins[19:8]);
      if (b && p) begin
        o_err = 1;
      end else begin
        if (b) t = bv + field;
        else if (p) begin
          sd = field;
          if (!e && field >= 2048) sd = field - 4096;
          if (e && field >= 524288) sd = field - 1048576;
          t = pv + sd;
        end else t = field;
        if (x) t = t + xv;
        o_ta  = t & 32'hFFFFF;
        o_imm = (i && !n) ? 1 : 0;
        o_ind = (n && !i) ? 1 : 0;
      end
    end
  endtask

  // reference model advance
  always @(posedge clk) begin
    int l, t, im, er, ind;
    if (rst_n) begin
      case (m_state)
        0: begin
          m_done = 0;
          if (req_valid) begin
            predict(instr, fmt_cls, int'(base_val), int'(index_val),
                    int'(pc_val), l, t, im, er, ind);
            m_len = l; m_ta = t; m_imm = im; m_err = er; m_tag = cur_tag;
            m_op  = ind ? 0 : t;
            m_state = ind ? 2 : 1;
          end
        end
        1: begin
          m_done = 1; m_have = 1; m_state = 0;
        end
        default: begin
          m_done = 0;
          if (rd_ready) begin
            m_op = int'(rd_data[19:0]);
            m_state = 1;
          end
        end
      endcase
    end
  end

  // memory responder with programmed stall
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_ready = (rd_cnt >= rd_wait);
      rd_cnt++;
    end else begin
      rd_ready = 1'b0;
      rd_cnt = 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_tag, "done", int'(done), int'(m_done));
      chk("R10", "req_ready", int'(req_ready), (m_state == 0) ? 1 : 0);
      chk(m_tag, "rd_valid", int'(rd_valid), (m_state == 2) ? 1 : 0);
      if (m_state == 2) chk(m_tag, "rd_addr", int'(rd_addr), m_ta);
      if (m_state == 0 && (m_done || m_have)) begin
        chk(m_tag, "len", int'(len), m_len);
        chk(m_tag, "ta", int'(ta), m_ta);
        chk(m_tag, "imm", int'(imm), m_imm);
        chk(m_tag, "err", int'(err), m_err);
        chk(m_tag, "op_addr", int'(op_addr), m_op);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk3(bit n, bit i, bit x, bit b, bit p, logic [11:0] d);
    return {6'h0B, n, i, x, b, p, 1'b0, d, 8'h00};
  endfunction

  function automatic logic [31:0] mk4(bit n, bit i, bit x, bit b, bit p, logic [19:0] a);
    return {6'h0B, n, i, x, b, p, 1'b1, a};
  endfunction

  task automatic send(string tag, logic [31:0] ins, logic [1:0] fc,
                      int bv, int xv, int pv, int wt, logic [23:0] word);
    @(negedge clk);
    cur_tag   = tag;
    instr     = ins;
    fmt_cls   = fc;
    base_val  = bv[19:0];
    index_val = xv[19:0];
    pc_val    = pv[19:0];
    rd_wait   = wt;
    rd_data   = word;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    instr     = 32'hFFFF_FFFF;
    while (!m_done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "req_ready", int'(req_ready), 1);
    chk("R11", "done", int'(done), 0);
    chk("R11", "rd_valid", int'(rd_valid), 0);
    chk("R11", "ta", int'(ta), 0);
    chk("R11", "op_addr", int'(op_addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send("R1", 32'hC4A0_0000, 2'b01, 5, 6, 7, 0, 24'h0);
    send("R1", 32'h9045_0000, 2'b10, 5, 6, 7, 0, 24'h0);
    send("R1", 32'h9045_0000, 2'b11, 5, 6, 7, 0, 24'h0);
    send("R8", mk3(1, 1, 0, 0, 0, 12'h123), 2'b00, 0, 0, 0, 0, 24'h0);
    send("R5", mk3(0, 0, 1, 0, 0, 12'h0F0), 2'b00, 0, 32'h00321, 0, 0, 24'h0);
    send("R3", mk3(1, 1, 0, 1, 0, 12'hFFF), 2'b00, 32'hFF800, 0, 0, 0, 24'h0);
    send("R3", mk3(1, 1, 1, 1, 0, 12'h010), 2'b00, 32'h01000, 32'h00005, 0, 0, 24'h0);
    send("R4", mk3(1, 1, 0, 0, 1, 12'h800), 2'b00, 0, 0, 32'h00100, 0, 24'h0);
    send("R4", mk3(1, 1, 0, 0, 1, 12'h7FF), 2'b00, 0, 0, 32'hFFF00, 0, 24'h0);
    send("R4", mk4(1, 1, 1, 0, 1, 20'hFFFF0), 2'b00, 0, 32'h00002, 32'h00040, 0, 24'h0);
    send("R2", mk4(1, 1, 1, 0, 0, 20'hABCDE), 2'b00, 0, 32'h54322, 0, 0, 24'h0);
    send("R2", mk4(1, 1, 0, 1, 0, 20'h12345), 2'b00, 32'h10000, 0, 0, 0, 24'h0);
    send("R6", mk3(0, 1, 0, 0, 0, 12'h05A), 2'b00, 0, 0, 0, 0, 24'h0);
    send("R6", mk4(0, 1, 0, 0, 1, 20'h00010), 2'b00, 0, 0, 32'h20000, 0, 24'h0);
    send("R7", mk3(1, 0, 0, 0, 0, 12'h200), 2'b00, 0, 0, 0, 0, 24'hF12345);
    send("R7", mk3(1, 0, 1, 1, 0, 12'h004), 2'b00, 32'h3000, 32'h10, 0, 3, 24'hA5EDCB);
    send("R7", mk4(1, 0, 0, 0, 0, 20'hFFFFF), 2'b00, 0, 0, 0, 7, 24'h0ABCDE);
    send("R8", mk3(0, 0, 0, 0, 1, 12'h004), 2'b00, 0, 0, 32'h00800, 0, 24'h0);
    send("R9", mk3(1, 0, 0, 1, 1, 12'h321), 2'b00, 32'h1000, 0, 32'h2000, 0, 24'h777777);
    send("R9", mk4(0, 1, 1, 1, 1, 20'h00001), 2'b00, 32'h1000, 32'h1, 0, 0, 24'h0);
    send("R10", mk3(1, 1, 0, 0, 0, 12'hABC), 2'b00, 0, 0, 0, 0, 24'h0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule